// File: doc/BRIEF.md
# Converter Command Port Serial Slave

This block is the serial front end of a data-converter style device. A host talks to it over a four-wire serial bus in clock mode 0. Every transaction opens with an eight-bit command byte. A mode bit inside that byte picks one of two field layouts. One layout issues a conversion, calibration or power-down order. The other layout opens a read or a write of one of 32 internal registers. The register's width sets how many data bits follow the command.

The serial pins are brought into the block's own clock domain through synchronizers and edge detectors, so the system clock must run several times faster than the serial clock. The block keeps a sticky power-down state and reports whether it is the light (standby) or deep (sleep) variant. It also emits single-cycle strobes that tell the converter core to start a conversion at a coded rate or to start a calibration.

Top module: `adc_cmd_slave`

## Requirements
- R1: A command byte whose bit 7 is 0 is ignored. For the rest of that transaction the slave leaves `spi_miso` undriven, emits no strobe, changes no register and leaves the power-down state as it was.
- R2: A command with bit 7 = 1, bit 6 = 0, bit 5 = 0 and bit 4 = 0 produces exactly one `conv_start` strobe, one clock long. While the strobe is high, `conv_rate` carries command bits 3:0. Extra serial clocks later in the same transaction produce no further strobe.
- R3: A command with bit 7 = 1, bit 6 = 0, bit 5 = 1 and bit 4 = 0 produces exactly one `cal_start` strobe, one clock long, and no `conv_start`.
- R4: A command with bit 7 = 1, bit 6 = 0 and bit 4 = 1 sets `pd_active` and emits no strobe. `pd_standby` takes bit 0 of register 0 as it stands at that moment: 1 selects standby, 0 selects sleep.
- R5: Power-down persists through register accesses and ignored commands. It clears only on a command with bit 7 = 1, bit 6 = 0 and bit 4 = 0.
- R6: A command with bits 7 and 6 set addresses register bits 5:1, and bit 0 = 0 selects a write. Data follows MSB first, one bit per rising serial clock. Registers 0-7 are 8 bits wide, registers 8-15 are 16 bits wide and registers 16-31 are 24 bits wide.
- R7: With bit 0 = 1 the register is read. Its MSB appears on `spi_miso` after the falling serial clock that follows the eighth command bit, and each later falling clock moves to the next bit. Bits clocked past the register width read as 0.
- R8: Write data bits beyond the addressed register's width are ignored.
- R9: If chip select rises partway through a write, the bits already received stay in the register and the unreached low bits keep their old values.
- R10: `spi_miso` is high impedance whenever chip select is high, and also throughout write, conversion and ignored transactions.
- R11: After reset all registers are zero, power-down is inactive and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low chip select framing one transaction |
| spi_mosi | input | 1 | Serial data from host, sampled on rising serial clock |
| spi_miso | output | 1 | Serial read data, changes on falling serial clock, high-Z when not reading |
| conv_start | output | 1 | One-cycle strobe: start a conversion |
| conv_rate | output | 4 | Rate code belonging to the latest conversion strobe |
| cal_start | output | 1 | One-cycle strobe: start a calibration |
| pd_active | output | 1 | Sticky power-down state |
| pd_standby | output | 1 | Power-down variant: 1 standby, 0 sleep |

## Verification
A bad bit counter or a bad decode state shows up within the same transaction. A read returns a shifted or truncated word, `spi_miso` drives when it should float, or a strobe goes missing or comes twice. A corrupted register bit stays hidden until that address is read back, so the bench reads back every address it writes, including after an aborted write. A lost or spurious power-down update shows up on `pd_active` a few clocks after the next idle gap begins, and the reference model compares it on every idle clock.

// File: rtl/adc_cmd_pkg.sv
// Shared constants and helpers for the converter command slave.
// Assumes an 8-bit command byte and at most 24-bit registers.
package adc_cmd_pkg;
    localparam int DATA_W      = 24;
    localparam int ADDR_W      = 5;
    localparam int NUM_REGS    = 1 << ADDR_W;
    localparam int CMD_W       = 8;
    localparam int CMD_CNT_W   = $clog2(CMD_W);
    localparam int CNT_W       = $clog2(DATA_W + 1);
    localparam int RATE_W      = 4;
    localparam int SYNC_STAGES = 2;

    localparam int BIT_START = CMD_W - 1;
    localparam int BIT_MODE  = CMD_W - 2;
    localparam int BIT_CAL   = CMD_W - 3;
    localparam int BIT_PD    = CMD_W - 4;
    localparam int BIT_DIR   = 0;

    localparam int W_SMALL   = 8;
    localparam int W_MID     = 16;
    localparam int SMALL_END = 8;
    localparam int MID_END   = 16;

    localparam int CTRL_ADDR = 0;
    localparam int STBY_BIT  = 0;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_IGNORE
    } eng_state_e;

    // Width in bits of the register at a given address.
    function automatic logic [CNT_W-1:0] reg_width(input logic [ADDR_W-1:0] a);
        if (int'(a) < SMALL_END)
            return CNT_W'(W_SMALL);
        else if (int'(a) < MID_END)
            return CNT_W'(W_MID);
        else
            return CNT_W'(DATA_W);
    endfunction
endpackage

// File: rtl/adc_cmd_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each input is stable for several clk cycles between changes.
module adc_cmd_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Each stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= RESET_VAL;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_cmd_engine.sv
// Transaction engine: collects the command byte, decodes it in either
// conversion or register-access layout, then runs the data phase.
// Assumes edge strobes already aligned to clk; cs_act is active high.
module adc_cmd_engine
    import adc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  wr_idx,
    output logic              wr_val,
    output logic              miso_bit,
    output logic              miso_oe,
    output logic              conv_req,
    output logic              cal_req,
    output logic              pd_set,
    output logic              pd_clr,
    output logic [RATE_W-1:0] rate
);
    localparam logic [CMD_CNT_W-1:0] LAST_CMD_BIT = CMD_CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0]     DATA_SAT     = CNT_W'(DATA_W);

    eng_state_e          state;
    logic [CMD_W-1:0]    cmd_sr;
    logic [CMD_W-1:0]    cmd_next;
    logic [CMD_CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0]    data_cnt;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   out_sr;
    logic [CNT_W-1:0]    wr_width;

    // Command byte as it will be once the current bit is taken.
    always_comb begin
        cmd_next = {cmd_sr[CMD_W-2:0], mosi_bit};
        rd_addr  = cmd_next[ADDR_W:1];
        wr_width = reg_width(addr_q);
    end

    // Read data leaves MSB first from the top of the shift register.
    always_comb begin
        miso_bit = out_sr[DATA_W-1];
        miso_oe  = (state == ST_READ);
        wr_addr  = addr_q;
    end

    // Transaction state, shifting and one-cycle request strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            cmd_sr   <= '0;
            bit_cnt  <= '0;
            data_cnt <= '0;
            addr_q   <= '0;
            out_sr   <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_val   <= 1'b0;
            conv_req <= 1'b0;
            cal_req  <= 1'b0;
            pd_set   <= 1'b0;
            pd_clr   <= 1'b0;
            rate     <= '0;
        end else begin
            wr_en    <= 1'b0;
            conv_req <= 1'b0;
            cal_req  <= 1'b0;
            pd_set   <= 1'b0;
            pd_clr   <= 1'b0;
            if (!cs_act) begin
                state    <= ST_CMD;
                bit_cnt  <= '0;
                data_cnt <= '0;
                out_sr   <= '0;
            end else begin
                case (state)
                    ST_CMD: begin
                        if (sclk_rise) begin
                            cmd_sr  <= cmd_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_CMD_BIT) begin
                                if (!cmd_next[BIT_START]) begin
                                    state <= ST_IGNORE;
                                end else if (cmd_next[BIT_MODE]) begin
                                    addr_q <= rd_addr;
                                    if (cmd_next[BIT_DIR]) begin
                                        state  <= ST_READ;
                                        out_sr <= rd_data << (DATA_W - int'(reg_width(rd_addr)));
                                    end else begin
                                        state <= ST_WRITE;
                                    end
                                end else begin
                                    state <= ST_DONE;
                                    if (cmd_next[BIT_PD]) begin
                                        pd_set <= 1'b1;
                                    end else begin
                                        pd_clr <= 1'b1;
                                        if (cmd_next[BIT_CAL]) begin
                                            cal_req <= 1'b1;
                                        end else begin
                                            conv_req <= 1'b1;
                                            rate     <= cmd_next[RATE_W-1:0];
                                        end
                                    end
                                end
                            end
                        end
                    end
                    ST_READ: begin
                        if (sclk_fall && data_cnt != '0)
                            out_sr <= out_sr << 1;
                        if (sclk_rise && data_cnt != DATA_SAT)
                            data_cnt <= data_cnt + 1'b1;
                    end
                    ST_WRITE: begin
                        if (sclk_rise && data_cnt < wr_width) begin
                            wr_en    <= 1'b1;
                            wr_idx   <= wr_width - CNT_W'(1) - data_cnt;
                            wr_val   <= mosi_bit;
                            data_cnt <= data_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/adc_cmd_regs.sv
// Register array with fixed per-address widths and single-bit writes.
// Bits above an address's width never change and read as 0.
module adc_cmd_regs
    import adc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_idx,
    input  logic              wr_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ctrl_standby
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [CNT_W-1:0] WID = reg_width(ADDR_W'(g));
            logic [DATA_W-1:0] q;
            // One register; a write lands only inside its width.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g) && wr_idx < WID)
                    q[wr_idx] <= wr_val;
            end
            assign mem[g] = q;
        end
    endgenerate

    assign rd_data      = mem[rd_addr];
    assign ctrl_standby = mem[CTRL_ADDR][STBY_BIT];
endmodule

// File: rtl/adc_cmd_pwr.sv
// Sticky power-down state; the variant is captured when it is entered.
module adc_cmd_pwr (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_set,
    input  logic pd_clr,
    input  logic ctrl_standby,
    output logic pd_active,
    output logic pd_standby
);
    // Enter on a power-down order, leave on a plain conversion-layout order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_active  <= 1'b0;
            pd_standby <= 1'b0;
        end else if (pd_set) begin
            pd_active  <= 1'b1;
            pd_standby <= ctrl_standby;
        end else if (pd_clr) begin
            pd_active  <= 1'b0;
            pd_standby <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_cmd_slave.sv
// Top of the converter command slave: synchronizes the serial pins,
// detects serial clock edges and ties engine, registers and power state.
// Assumes clk runs at least eight times faster than spi_sclk.
module adc_cmd_slave
    import adc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              conv_start,
    output logic [RATE_W-1:0] conv_rate,
    output logic              cal_start,
    output logic              pd_active,
    output logic              pd_standby
);
    logic [2:0]        pins_s;
    logic              csn_s, sclk_s, mosi_s, sclk_q;
    logic              sclk_rise, sclk_fall;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [CNT_W-1:0]  wr_idx;
    logic              wr_en, wr_val;
    logic              miso_bit, miso_oe_w;
    logic              pd_set, pd_clr, ctrl_standby;

    adc_cmd_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_sclk, spi_mosi}),
        .q     (pins_s)
    );

    assign {csn_s, sclk_s, mosi_s} = pins_s;

    // Delayed copy of the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk_q <= 1'b0;
        else
            sclk_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;

    adc_cmd_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (~csn_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_bit  (mosi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .miso_bit  (miso_bit),
        .miso_oe   (miso_oe_w),
        .conv_req  (conv_start),
        .cal_req   (cal_start),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .rate      (conv_rate)
    );

    adc_cmd_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_idx       (wr_idx),
        .wr_val       (wr_val),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .ctrl_standby (ctrl_standby)
    );

    adc_cmd_pwr u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_set       (pd_set),
        .pd_clr       (pd_clr),
        .ctrl_standby (ctrl_standby),
        .pd_active    (pd_active),
        .pd_standby   (pd_standby)
    );

    assign spi_miso = miso_oe_w ? miso_bit : 1'bz;
endmodule

// File: rtl/adc_cmd_slave_chk.sv
// Temporal checks for adc_cmd_slave, attached through bind.
module adc_cmd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_csn,
    input logic miso_oe,
    input logic conv_start,
    input logic cal_start,
    input logic pd_active,
    input logic pd_standby
);
    p_conv_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_cal_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && cal_start));

    p_standby_in_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_standby |-> pd_active);

    p_conv_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !pd_active);

    p_pd_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
        |=> $stable(pd_active));

    p_miso_idle_z_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
        |-> !miso_oe);
endmodule

bind adc_cmd_slave adc_cmd_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .miso_oe    (miso_oe_w),
    .conv_start (conv_start),
    .cal_start  (cal_start),
    .pd_active  (pd_active),
    .pd_standby (pd_standby)
);

// File: tb/adc_cmd_slave_bench.sv
module adc_cmd_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_mosi = 1'b0;
    wire        spi_miso;
    logic       conv_start, cal_start, pd_active, pd_standby;
    logic [3:0] conv_rate;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 0;
    bit finished = 0;
    bit drove = 0;
    int conv_cnt = 0;
    int cal_cnt = 0;
    logic [3:0] last_rate = '0;
    int idle_cnt = 0;

    logic [23:0] model_mem [32];
    bit          model_pd = 0;
    bit          model_stby = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_cmd_slave u_adc_cmd_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_csn    (spi_csn),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .conv_start (conv_start),
        .conv_rate  (conv_rate),
        .cal_start  (cal_start),
        .pd_active  (pd_active),
        .pd_standby (pd_standby)
    );

    function automatic int width_of(input int a);
        if (a < 8) return 8;
        if (a < 16) return 16;
        return 24;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock monitor: strobes, idle output state and power model.
    always @(negedge clk) begin
        if (live) begin
            if (conv_start) begin conv_cnt++; last_rate = conv_rate; end
            if (cal_start) cal_cnt++;
            if (spi_miso !== 1'bz) drove = 1;
            idle_cnt = spi_csn ? idle_cnt + 1 : 0;
            if (idle_cnt >= 4) begin
                chk("R10", "idle miso", {31'd0, spi_miso === 1'bz}, 32'd1);
                chk("R5", "pd_active vs model", {31'd0, pd_active}, {31'd0, model_pd});
                chk("R4", "pd_standby vs model", {31'd0, pd_standby}, {31'd0, model_stby});
            end
        end
    end

    // One transaction; optional power model update while chip select is low.
    task automatic xfer(input logic [7:0] cmd, input int nbits, input logic [31:0] dv,
                        output logic [31:0] rv, input bit upd = 0,
                        input bit new_pd = 0, input bit new_stby = 0);
        logic [39:0] frame;
        frame = {cmd, dv};
        rv = '0;
        drove = 0;
        conv_cnt = 0;
        cal_cnt = 0;
        @(negedge clk);
        spi_csn = 1'b0;
        if (upd) begin model_pd = new_pd; model_stby = new_stby; end
        repeat (HP) @(negedge clk);
        for (int i = 0; i < 8 + nbits; i++) begin
            spi_mosi = frame[39 - i];
            repeat (HP) @(negedge clk);
            spi_sclk = 1'b1;
            if (i >= 8) rv[31 - (i - 8)] = (spi_miso === 1'b1);
            repeat (HP) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        spi_csn = 1'b1;
        spi_mosi = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] val, input int nbits, input string req);
        logic [31:0] dv, rv;
        int w;
        dv = val << (32 - nbits);
        w = width_of(a);
        xfer({2'b11, a[4:0], 1'b0}, nbits, dv, rv);
        for (int i = 0; i < nbits && i < w; i++) model_mem[a][w - 1 - i] = dv[31 - i];
        chk(req, "write leaves miso undriven", {31'd0, drove}, 32'd0);
    endtask

    task automatic rd_reg(input int a, input int nbits, input string req);
        logic [31:0] rv, exp;
        int w;
        w = width_of(a);
        xfer({2'b11, a[4:0], 1'b1}, nbits, 32'd0, rv);
        exp = {8'd0, model_mem[a]} << (32 - w);
        exp = exp & ~(32'hFFFF_FFFF >> nbits);
        chk(req, $sformatf("read reg %0d", a), rv, exp);
    endtask

    task automatic conv_cmd(input logic [7:0] cmd, input int extra, input string req);
        logic [31:0] rv;
        bit np, ns, up;
        up = 1;
        np = cmd[4];
        ns = cmd[4] ? model_mem[0][0] : 1'b0;
        xfer(cmd, extra, 32'hFFFF_FFFF, rv, up, np, ns);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model_mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1;
        // R11 reset state
        chk("R11", "pd_active after reset", {31'd0, pd_active}, 32'd0);
        chk("R11", "conv_start after reset", {31'd0, conv_start}, 32'd0);
        chk("R11", "cal_start after reset", {31'd0, cal_start}, 32'd0);
        rd_reg(20, 24, "R11");
        rd_reg(5, 8, "R11");
        // R6 R7 full-width write and read
        wr_reg(20, 32'h123456, 24, "R6");
        rd_reg(20, 24, "R7");
        wr_reg(9, 32'hBEEF, 16, "R6");
        rd_reg(9, 24, "R7");
        // R8 extra write bits ignored
        wr_reg(3, 32'hA55A, 16, "R8");
        chk("R8", "model reg3", {8'd0, model_mem[3]}, 32'h0000_00A5);
        rd_reg(3, 16, "R8");
        // R9 aborted write keeps partial bits
        wr_reg(20, 32'hAB, 8, "R9");
        chk("R9", "model reg20", {8'd0, model_mem[20]}, 32'h00AB_3456);
        rd_reg(20, 24, "R9");
        // R2 conversion strobes
        conv_cmd(8'h89, 0, "R2");
        chk("R2", "conv count", conv_cnt, 1);
        chk("R2", "conv rate", {28'd0, last_rate}, 32'h9);
        chk("R2", "no cal", cal_cnt, 0);
        conv_cmd(8'h8F, 8, "R2");
        chk("R2", "conv count with extra clocks", conv_cnt, 1);
        chk("R2", "conv rate F", {28'd0, last_rate}, 32'hF);
        chk("R10", "conv leaves miso undriven", {31'd0, drove}, 32'd0);
        // R3 calibration strobe
        conv_cmd(8'hA3, 0, "R3");
        chk("R3", "cal count", cal_cnt, 1);
        chk("R3", "no conv on cal", conv_cnt, 0);
        // R4 sleep power-down
        conv_cmd(8'h90, 0, "R4");
        chk("R4", "no strobe on pd", conv_cnt + cal_cnt, 0);
        chk("R4", "pd_active set", {31'd0, pd_active}, 32'd1);
        chk("R4", "sleep variant", {31'd0, pd_standby}, 32'd0);
        // R5 persistence through register access and ignored command
        wr_reg(17, 32'h00C0FFEE, 24, "R5");
        rd_reg(17, 24, "R5");
        begin
            logic [31:0] rv;
            xfer(8'h12, 8, 32'd0, rv);
        end
        chk("R5", "pd held", {31'd0, pd_active}, 32'd1);
        conv_cmd(8'h84, 0, "R5");
        chk("R5", "pd cleared", {31'd0, pd_active}, 32'd0);
        chk("R5", "conv on wake", conv_cnt, 1);
        // R4 standby variant from register 0 bit 0
        wr_reg(0, 32'h01, 8, "R4");
        conv_cmd(8'h95, 0, "R4");
        chk("R4", "standby variant", {31'd0, pd_standby}, 32'd1);
        conv_cmd(8'hA0, 0, "R5");
        chk("R5", "cal clears pd", {31'd0, pd_active}, 32'd0);
        chk("R3", "cal count on wake", cal_cnt, 1);
        // R1 ignored command
        conv_cmd(8'h90, 0, "R1");
        begin
            logic [31:0] rv;
            xfer(8'h7E, 24, 32'hFFFF_FF00, rv);
            chk("R1", "ignored no drive", {31'd0, drove}, 32'd0);
            chk("R1", "ignored no strobe", conv_cnt + cal_cnt, 0);
            xfer(8'h3F, 8, 32'd0, rv);
            chk("R1", "ignored no drive 2", {31'd0, drove}, 32'd0);
        end
        chk("R1", "pd unchanged", {31'd0, pd_active}, 32'd1);
        rd_reg(31, 24, "R1");
        repeat (10) @(negedge clk);
        finished = 1;
        summary();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end
endmodule